// File: doc/BRIEF.md
# Floating-Point Shared-Stage Issue Guard

This block sits in front of a group of floating-point execution units whose internal stages are shared: the unpacker, the operand shifter, the mantissa adder, the rounder, the exception tester, two multiplier stages and a divide stage. Every operation class follows a fixed schedule of which of these stages it holds in each cycle after it enters. The guard keeps an occupancy horizon for each stage and compares an incoming request's schedule against it. If there is no overlap, it grants the request in the same cycle. If there is an overlap, it raises stall, and the requester holds its request and tries again on the next cycle.

Only the timing of stage use is modelled here; no arithmetic passes through the block. The multiplier's last two steps borrow the adder's add and round stages, so a multiply that is already in flight can block a later add or compare. For this reason the guard tracks stages rather than whole units.

Top module: `fp_stage_guard`

## Requirements
- R1: `op_class` encodes the operation: 0 = add/subtract, 1 = multiply, 2 = negate/absolute value, 3 = compare. All four codes are legal.
- R2: When `op_valid` is high and none of the requested stage slots are booked, `grant` is high in that same cycle. `stall` equals `op_valid` and not `grant`. With `op_valid` low, both outputs are low.
- R3: An add/subtract granted in cycle t holds unpack at t, shift and add at t+1, add and round at t+2, and round and shift at t+3.
- R4: A multiply granted in cycle t holds unpack at t, exception test and multiplier stage one at t+1, multiplier stage one at t+2 through t+4, multiplier stage two at t+5 and t+6, the adder's add stage at t+6, and round at t+7.
- R5: A negate or absolute-value operation granted at t holds unpack at t and shift at t+1.
- R6: A compare granted at t holds unpack at t, add at t+1 and round at t+2.
- R7: The add and round slots that a multiply books collide with add/subtract and compare requests. For example, an add requested five cycles after a multiply grant is stalled.
- R8: A stalled request books nothing. When it is retried on later cycles, it is granted in the first cycle in which its schedule is free. At most one operation is granted per cycle.
- R9: The synchronous active-low reset `rst_n` clears every booking at the clock edge. While `rst_n` is low, `grant` stays low.
- R10: A booked slot is held until its cycle has passed and is never released early. Each clock advances every horizon by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A request is presented this cycle |
| op_class | input | 2 | Operation class code (see R1) |
| grant | output | 1 | The request enters the units this cycle |
| stall | output | 1 | The request must be held and retried |

## Verification
The assertions assume that a requester which sees stall keeps `op_valid` high and keeps the same `op_class` in the next cycle. They also assume that every class code is meaningful, which holds because the 2-bit field has no spare values. The stimulus respects both assumptions: every request is issued through a retry task that re-presents the same class until it is granted, and idle gaps occur only between completed grants. Directed sequences place a multiply followed by an add or compare at the offsets where the borrowed adder slots collide. A reset is issued while work is in flight, and random class and gap mixes cover the remaining cases.

// File: rtl/fpsc_pkg.sv
// Package for the shared-stage issue guard.
// Holds the stage indices, the class encoding and the booking-map types.
// Assumes schedules never run longer than PAT_DEPTH cycles.
package fpsc_pkg;

    localparam int NUM_RES   = 8;
    localparam int PAT_DEPTH = 8;
    localparam int CLS_W     = 2;

    // stage indices into a booking map
    localparam int RES_U = 0;   // unpack
    localparam int RES_S = 1;   // operand shift
    localparam int RES_A = 2;   // mantissa add
    localparam int RES_R = 3;   // round
    localparam int RES_E = 4;   // exception test
    localparam int RES_M = 5;   // multiplier stage one
    localparam int RES_N = 6;   // multiplier stage two
    localparam int RES_D = 7;   // divide (never booked by modelled classes)

    typedef enum logic [CLS_W-1:0] {
        OPC_ADDSUB = 2'd0,
        OPC_MUL    = 2'd1,
        OPC_SIGN   = 2'd2,
        OPC_CMP    = 2'd3
    } op_class_e;

    typedef logic [PAT_DEPTH-1:0]              lane_t;
    typedef logic [NUM_RES-1:0][PAT_DEPTH-1:0] resv_map_t;

endpackage

// File: rtl/fpsc_pattern_rom.sv
// Schedule table for the shared-stage issue guard.
// Maps an operation class to its booking map: bit k of lane r means that
// stage r is held k cycles after the grant (k = 0 is the grant cycle).
// Purely combinational; assumes every class code is defined.
module fpsc_pattern_rom
    import fpsc_pkg::*;
(
    input  op_class_e cls_i,
    output resv_map_t map_o
);

    // build the booking map of the presented class
    always_comb begin
        map_o = '0;
        case (cls_i)
            OPC_ADDSUB: begin
                map_o[RES_U][0] = 1'b1;
                map_o[RES_S][1] = 1'b1;
                map_o[RES_A][1] = 1'b1;
                map_o[RES_A][2] = 1'b1;
                map_o[RES_R][2] = 1'b1;
                map_o[RES_R][3] = 1'b1;
                map_o[RES_S][3] = 1'b1;
            end
            OPC_MUL: begin
                map_o[RES_U][0] = 1'b1;
                map_o[RES_E][1] = 1'b1;
                for (int k = 1; k <= 4; k++) begin
                    map_o[RES_M][k] = 1'b1;
                end
                map_o[RES_N][5] = 1'b1;
                map_o[RES_N][6] = 1'b1;
                map_o[RES_A][6] = 1'b1;
                map_o[RES_R][7] = 1'b1;
            end
            OPC_SIGN: begin
                map_o[RES_U][0] = 1'b1;
                map_o[RES_S][1] = 1'b1;
            end
            OPC_CMP: begin
                map_o[RES_U][0] = 1'b1;
                map_o[RES_A][1] = 1'b1;
                map_o[RES_R][2] = 1'b1;
            end
            default: map_o = '0;
        endcase
    end

endmodule

// File: rtl/fpsc_resv_lane.sv
// Booking horizon for one shared stage.
// Bit k of the horizon means the stage is held k cycles from now.
// Reports whether the offered schedule overlaps the horizon, merges the
// schedule in when book_i is high, and advances one cycle per clock.
// Assumes book_i is high only when hit_o is low.
module fpsc_resv_lane #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             book_i,
    input  logic [DEPTH-1:0] pat_i,
    output logic             hit_o
);

    logic [DEPTH-1:0] occ_q;

    // overlap between the offered schedule and current bookings
    always_comb hit_o = |(occ_q & pat_i);

    // merge a granted schedule and advance the horizon by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= (occ_q | (book_i ? pat_i : '0)) >> 1;
        end
    end

    // R9: the horizon is empty after a reset edge
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> (occ_q == '0));

    // R10: a granted schedule is present, one cycle advanced, after the edge
    p_resv_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        book_i |=> ((occ_q & ($past(pat_i) >> 1)) == ($past(pat_i) >> 1)));

    // R10: no booked slot disappears other than by passing its cycle
    p_shift_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((occ_q[DEPTH-2:0] & $past(occ_q[DEPTH-1:1]))
                   == $past(occ_q[DEPTH-1:1])));

endmodule

// File: rtl/fp_stage_guard.sv
// Issue guard for floating-point units with shared internal stages.
// Looks up the schedule of the requested class, checks it against one
// booking lane per stage, and grants in the same cycle when all lanes are
// clear. Assumes a stalled request is held unchanged until it is granted.
module fp_stage_guard
    import fpsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [CLS_W-1:0] op_class,
    output logic             grant,
    output logic             stall
);

    op_class_e          cls;
    resv_map_t          pat_map;
    logic [NUM_RES-1:0] lane_hit;

    // interpret the class field
    always_comb cls = op_class_e'(op_class);

    fpsc_pattern_rom u_rom (
        .cls_i (cls),
        .map_o (pat_map)
    );

    // one booking lane per shared stage
    for (genvar r = 0; r < NUM_RES; r++) begin : g_lane
        fpsc_resv_lane #(.DEPTH(PAT_DEPTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .book_i (grant),
            .pat_i  (pat_map[r]),
            .hit_o  (lane_hit[r])
        );
    end

    // grant when no lane reports an overlap; otherwise hold the requester
    always_comb begin
        grant = op_valid & rst_n & ~(|lane_hit);
        stall = op_valid & ~grant;
    end

    // R8: input contract, a stalled request is re-presented unchanged
    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (op_valid && $stable(op_class)));

    // R7: a multiply's borrowed adder slot blocks an add five cycles later
    p_mul_blocks_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && op_class == OPC_MUL) ##5 (op_valid && op_class == OPC_ADDSUB)
        |-> stall);

endmodule

// File: tb/fp_stage_guard_tb.sv
// Bench for fp_stage_guard: a behavioural model keeps the booked
// (cycle, stage) pairs in an associative array and predicts grant and
// stall for every clock.
module fp_stage_guard_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_class = 2'd0;
    logic       grant;
    logic       stall;

    int  checks = 0;
    int  fails = 0;
    int  now_cyc = 0;
    bit  done = 0;
    bit  booked[int];
    int  lfsr = 32'h1d2c3b4a;

    fp_stage_guard u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_class (op_class),
        .grant    (grant),
        .stall    (stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench-side stage numbers: 0 U, 1 S, 2 A, 3 R, 4 E, 5 M, 6 N, 7 D
    function automatic bit uses(int c, int r, int k);
        case (c)
            0: return (r==0 && k==0) || (r==1 && (k==1 || k==3)) ||
                      (r==2 && (k==1 || k==2)) || (r==3 && (k==2 || k==3));
            1: return (r==0 && k==0) || (r==4 && k==1) ||
                      (r==5 && k>=1 && k<=4) || (r==6 && (k==5 || k==6)) ||
                      (r==2 && k==6) || (r==3 && k==7);
            2: return (r==0 && k==0) || (r==1 && k==1);
            default: return (r==0 && k==0) || (r==2 && k==1) || (r==3 && k==2);
        endcase
    endfunction

    function automatic bit model_free(int c);
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++)
                if (uses(c, r, k) && booked.exists((now_cyc + k) * 8 + r))
                    return 1'b0;
        return 1'b1;
    endfunction

    function automatic string ctag(int c, bit v);
        if (!v) return "R2";
        case (c)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int rnd(int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return (lfsr & 32'h7fffffff) % m;
    endfunction

    // one clock: drive, compare with the model, update the model
    task automatic cycle(input bit rs, input bit v, input int c,
                         input string ph, output bit g);
        bit exp_g, exp_s;
        @(negedge clk);
        rst_n = rs;
        op_valid = v;
        op_class = c[1:0];
        #1;
        exp_g = rs && v && model_free(c);
        exp_s = v && !exp_g;
        checks++;
        if ({grant, stall} !== {exp_g, exp_s}) begin
            fails++;
            $display("FAIL %s/%s cycle %0d class %0d: grant,stall actual=%b%b expected=%b%b",
                     ph, ctag(c, v), now_cyc, c, grant, stall, exp_g, exp_s);
        end
        if (exp_g)
            for (int r = 0; r < 8; r++)
                for (int k = 0; k < 8; k++)
                    if (uses(c, r, k)) booked[(now_cyc + k) * 8 + r] = 1'b1;
        if (!rs) booked.delete();
        g = exp_g;
        @(posedge clk);
        now_cyc++;
    endtask

    // R8: present one request and hold it until granted
    task automatic issue(input int c, input string ph);
        bit g;
        int tries = 0;
        do begin
            cycle(1'b1, 1'b1, c, ph, g);
            tries++;
        end while (!g && tries < 64);
    endtask

    task automatic idle(input int n, input string ph);
        bit g;
        for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 0, ph, g);
    endtask

    initial begin
        bit g;
        // R9: reset state, and no grant while reset is low
        cycle(1'b0, 1'b0, 0, "R9", g);
        cycle(1'b0, 1'b1, 1, "R9", g);
        cycle(1'b0, 1'b0, 0, "R9", g);
        idle(2, "R2");
        // R3: single add, then back-to-back adds
        issue(0, "R3");
        idle(4, "R3");
        issue(0, "R8");
        issue(0, "R8");
        issue(0, "R8");
        idle(4, "R8");
        // R5: sign ops every cycle
        for (int i = 0; i < 4; i++) issue(2, "R5");
        idle(2, "R5");
        // R6: compares back to back
        issue(3, "R6");
        issue(3, "R6");
        idle(3, "R6");
        // R4: multiplies back to back
        issue(1, "R4");
        issue(1, "R4");
        idle(9, "R4");
        // R7: add and compare meeting a multiply's adder slots
        issue(1, "R7");
        idle(4, "R7");
        issue(0, "R7");
        idle(8, "R7");
        issue(1, "R7");
        idle(4, "R7");
        issue(3, "R7");
        idle(8, "R7");
        // R9: reset while a multiply is in flight
        issue(1, "R9");
        cycle(1'b0, 1'b0, 0, "R9", g);
        issue(1, "R9");
        idle(8, "R10");
        // R1, R10: random class and gap mix
        for (int i = 0; i < 400; i++) begin
            idle(rnd(3), "R10");
            issue(rnd(4), "R1");
        end
        idle(8, "R10");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule